// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a single-cycle 32-bit processor. It also chooses the address the counter loads on the next clock edge. Each cycle the counter moves to exactly one of three candidates:

- the sequential address, which is the current PC plus four;
- a conditional-branch target, which is PC plus four plus the word-scaled immediate offset;
- an absolute jump target, formed from the upper bits of PC plus four and the 26-bit word index in the instruction.

Branch-on-equal is taken only when the decoder flags a branch and the ALU's subtraction result is all zeros. A jump overrides every other choice.

The decoder drives the branch and jump flags. The ALU supplies its result, from which the block derives the equality flag itself. The sign-extender supplies the widened immediate, and the instruction supplies the jump field. The current PC is a registered output that feeds instruction fetch directly.

Top module: `pc_next_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pc` becomes 0x00000000 after that edge.
- R2: With `jmp_en` low and `br_en` low, `pc` advances by 4 at each edge, whatever the ALU result.
- R3: The equality flag is 1 exactly when all 32 bits of `alu_res` are zero; no other value counts as equal.
- R4: With `br_en` high, `jmp_en` low and `alu_res` zero, the next `pc` is (pc + 4) + (imm_ext << 2), modulo 2^32.
- R5: With `br_en` high, `jmp_en` low and `alu_res` nonzero, the next `pc` is pc + 4.
- R6: A zero `alu_res` while `br_en` is low has no effect: the next `pc` is pc + 4.
- R7: With `jmp_en` high, the next `pc` is {(pc+4)[31:28], jaddr[25:0], 2'b00}.
- R8: When `jmp_en` is high and a branch would also be taken, the jump target wins.
- R9: `pc[1:0]` is 2'b00 at every edge outside reset.
- R10: Sequential stepping wraps modulo 2^32, so 0xFFFFFFFC is followed by 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| br_en | input | 1 | Decoder flag: current instruction is branch-on-equal |
| jmp_en | input | 1 | Decoder flag: current instruction is an unconditional jump |
| alu_res | input | 32 | ALU subtraction result used for the equality test |
| imm_ext | input | 32 | Sign-extended 16-bit immediate (word offset) |
| jaddr | input | 26 | Jump word-index field of the instruction |
| pc | output | 32 | Current program counter (registered) |

## Verification
Directed steps cover several distinct cases:

- a plain sequential advance;
- a taken and a not-taken branch, which differ only in whether `alu_res` is zero;
- a zero result with no branch flag, which shows the equality flag alone cannot redirect the counter;
- a backward branch with a negative offset.

Further directed steps exercise the jump path:

- a branch with a large offset moves the counter into a region whose top nibble is nonzero;
- the jumps that follow show whether the upper bits come from PC+4 and not from zero;
- a jump issued together with a taken branch separates the priority order;
- an all-ones jump field followed by a sequential step exposes the wrap at the top of the address space.

A seeded random stream then mixes all flag combinations, near-zero ALU values and signed offsets, with occasional resets, against a bench reference model.

// File: rtl/pc_next_pkg.sv
package pc_next_pkg;

  // Which candidate the counter loads on the next edge
  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BR  = 2'd1,
    SRC_JMP = 2'd2
  } pc_src_e;

endpackage

// File: rtl/pcnu_zero_detect.sv
module pcnu_zero_detect #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] value,
  output logic              is_zero
);

  // R3: equality means every bit of the difference is clear
  always_comb begin
    is_zero = ~(|value);
  end

endmodule

// File: rtl/pcnu_target_calc.sv
module pcnu_target_calc #(
  parameter int ADDR_W  = 32,
  parameter int JFIELD_W = 26
) (
  input  logic [ADDR_W-1:0]   pc_cur,
  input  logic [ADDR_W-1:0]   imm_ext,
  input  logic [JFIELD_W-1:0] jaddr,
  output logic [ADDR_W-1:0]   seq_addr,
  output logic [ADDR_W-1:0]   br_addr,
  output logic [ADDR_W-1:0]   jmp_addr
);

  localparam int UP_W = ADDR_W - JFIELD_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] off_scaled;

  always_comb begin
    seq_addr   = pc_cur + STEP;
    off_scaled = imm_ext << 2;
    br_addr    = seq_addr + off_scaled;
  end

  // Upper region bits exist only when the field does not fill the address
  generate
    if (UP_W > 0) begin : g_region
      always_comb jmp_addr = {seq_addr[ADDR_W-1 -: UP_W], jaddr, 2'b00};
    end else begin : g_flat
      always_comb jmp_addr = ADDR_W'({jaddr, 2'b00});
    end
  endgenerate

endmodule

// File: rtl/pcnu_next_sel.sv
module pcnu_next_sel
  import pc_next_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              br_en,
  input  logic              jmp_en,
  input  logic              is_zero,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic [ADDR_W-1:0] jmp_addr,
  output pc_src_e           src,
  output logic [ADDR_W-1:0] next_addr
);

  // Jump first, then taken branch, else sequential
  always_comb begin
    if (jmp_en)                 src = SRC_JMP;
    else if (br_en && is_zero)  src = SRC_BR;
    else                        src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_JMP: next_addr = jmp_addr;
      SRC_BR:  next_addr = br_addr;
      default: next_addr = seq_addr;
    endcase
  end

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pc_next_pkg::*;
#(
  parameter int               ADDR_W     = 32,
  parameter int               JFIELD_W   = 26,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                br_en,
  input  logic                jmp_en,
  input  logic [ADDR_W-1:0]   alu_res,
  input  logic [ADDR_W-1:0]   imm_ext,
  input  logic [JFIELD_W-1:0] jaddr,
  output logic [ADDR_W-1:0]   pc
);

  localparam int UP_W = ADDR_W - JFIELD_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] seq_addr, br_addr, jmp_addr, next_addr;
  logic              is_zero;
  pc_src_e           src;

  pcnu_zero_detect #(.DATA_W(ADDR_W)) u_zero (
    .value   (alu_res),
    .is_zero (is_zero)
  );

  pcnu_target_calc #(.ADDR_W(ADDR_W), .JFIELD_W(JFIELD_W)) u_tgt (
    .pc_cur   (pc_q),
    .imm_ext  (imm_ext),
    .jaddr    (jaddr),
    .seq_addr (seq_addr),
    .br_addr  (br_addr),
    .jmp_addr (jmp_addr)
  );

  pcnu_next_sel #(.ADDR_W(ADDR_W)) u_sel (
    .br_en     (br_en),
    .jmp_en    (jmp_en),
    .is_zero   (is_zero),
    .seq_addr  (seq_addr),
    .br_addr   (br_addr),
    .jmp_addr  (jmp_addr),
    .src       (src),
    .next_addr (next_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_ADDR;
    else     pc_q <= next_addr;
  end

  assign pc = pc_q;

  // Assertions next to the counter register
  p_reset_load_r1: assert property (@(posedge clk)
    rst |=> pc == RESET_ADDR);

  // R2 and R6: no branch flag means a plain step (R10 wrap is modular)
  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!jmp_en && !br_en) |=> pc == $past(pc) + STEP);

  p_taken_r4: assert property (@(posedge clk) disable iff (rst)
    (!jmp_en && br_en && alu_res == '0) |=>
      pc == $past(pc) + STEP + ($past(imm_ext) << 2));

  p_not_taken_r5: assert property (@(posedge clk) disable iff (rst)
    (!jmp_en && br_en && alu_res != '0) |=> pc == $past(pc) + STEP);

  p_jump_field_r7: assert property (@(posedge clk) disable iff (rst)
    jmp_en |=> pc[JFIELD_W+1:2] == $past(jaddr));

  generate
    if (UP_W > 0) begin : g_chk_region
      p_jump_region_r7: assert property (@(posedge clk) disable iff (rst)
        jmp_en |=> pc[ADDR_W-1 -: UP_W] == $past(seq_addr[ADDR_W-1 -: UP_W]));
    end
  endgenerate

  p_jump_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (jmp_en && br_en && alu_res == '0) |=> pc[JFIELD_W+1:2] == $past(jaddr));

  p_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

endmodule

// File: tb/sim_pc_next_unit.sv
`timescale 1ns/1ps
module sim_pc_next_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        br_en, jmp_en;
  logic [31:0] alu_res, imm_ext;
  logic [25:0] jaddr;
  logic [31:0] pc;

  int checks = 0;
  int errors = 0;
  logic [31:0] model;

  always #2 clk = ~clk;

  pc_next_unit u0 (
    .clk(clk), .rst(rst), .br_en(br_en), .jmp_en(jmp_en),
    .alu_res(alu_res), .imm_ext(imm_ext), .jaddr(jaddr), .pc(pc)
  );

  function automatic logic [31:0] ref_next(input logic [31:0] cur, input logic b,
      input logic j, input logic [31:0] a, input logic [31:0] im, input logic [25:0] ja);
    logic [31:0] p4;
    p4 = cur + 32'd4;
    if (j)                   return {p4[31:28], ja, 2'b00};
    else if (b && a == 32'd0) return p4 + {im[29:0], 2'b00};
    else                     return p4;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, clock once, check at the following negedge
  task automatic step(input logic b, input logic j, input logic [31:0] a,
      input logic [31:0] im, input logic [25:0] ja, input string req);
    br_en = b; jmp_en = j; alu_res = a; imm_ext = im; jaddr = ja;
    model = ref_next(model, b, j, a, im, ja);
    @(posedge clk); @(negedge clk);
    chk(pc, model, req);
    chk({30'd0, pc[1:0]}, 32'd0, "R9");
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    model = 32'd0;
    chk(pc, 32'd0, "R1");
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    rst = 1'b1; br_en = 0; jmp_en = 0; alu_res = 0; imm_ext = 0; jaddr = 0;
    model = 0;
    @(negedge clk);
    do_reset();

    step(0, 0, 32'h5, 32'h0, 26'h0, "R2");
    step(1, 0, 32'h0, 32'h10, 26'h0, "R4 taken");
    step(1, 0, 32'h1, 32'h40, 26'h0, "R5 not taken");
    step(1, 0, 32'h8000_0000, 32'h40, 26'h0, "R3 top bit only");
    step(0, 0, 32'h0, 32'h40, 26'h0, "R6 zero without branch");
    step(1, 0, 32'h0, 32'hFFFF_FFFE, 26'h0, "R4 backward");
    // Large offset moves into region 0x3xxxxxxx
    step(1, 0, 32'h0, 32'h0C00_0000, 26'h0, "R4 far");
    step(0, 1, 32'h7, 32'h0, 26'h0AB_CDE, "R7 nonzero region");
    step(1, 1, 32'h0, 32'h100, 26'h12_3456, "R8 jump over branch");
    // Reach top nibble F, jump to the last word, then wrap
    step(1, 0, 32'h0, 32'h3000_0000, 26'h0, "R4 to region F");
    step(0, 1, 32'h1, 32'h0, 26'h3FF_FFFF, "R7 last word");
    chk(pc, 32'hFFFF_FFFC, "R7 absolute");
    step(0, 0, 32'h1, 32'h0, 26'h0, "R10 wrap");
    chk(pc, 32'h0, "R10 absolute");

    for (int i = 0; i < 400; i++) begin
      logic b, j;
      logic [31:0] a, im;
      logic [15:0] raw;
      if (i % 97 == 96) do_reset();
      b = $urandom_range(0, 1) == 1;
      j = $urandom_range(0, 5) == 0;
      a = ($urandom_range(0, 1) == 1) ? 32'd0 : (32'd1 << $urandom_range(0, 31));
      raw = 16'($urandom);
      im = {{16{raw[15]}}, raw};
      step(b, j, a, im, 26'($urandom), "R2/R4/R5/R7 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule